// File: doc/BRIEF.md
# Vertical Sync Detector with Default Timeout

This block watches a digitized composite sync stream (active low, asynchronous to the system clock) and drives an active-low vertical sync pulse. It measures how long each low interval of the incoming sync lasts. A low interval of at least a set number of timebase ticks counts as a broad (serration) pulse, and anything shorter counts as an ordinary line pulse or an equalizing pulse. The falling edge of the output marks the start of the vertical period. That edge is launched by the rising edge that ends the first broad pulse.

If broad pulses never show up and the input simply stays low, a fallback timer starts the same pulse once the low interval has lasted the default delay. The output pulse always lasts the same number of ticks, whichever path started it. All durations are counted in ticks of an external timebase strobe, so a single strobe rate scales every delay and width together.

After a pulse has fired, the detector ignores every trigger until the pulse has ended and a short sync pulse has been seen. This keeps the broad pulses that follow in the same vertical interval from retriggering it.

Top module: `vsync_detector`

## Requirements
- R1: While `rst` is high at a clock edge, `vsync_n` is driven high after that edge. Reset also clears the low-time counter and the width counter and arms the detector.
- R2: The low time is the number of cycles with `tick` high during which the synchronized input is low. A rising edge ends a broad pulse when this count is at least SERR_TICKS (default 16). A low of exactly SERR_TICKS ticks is broad, and one of SERR_TICKS-1 ticks is short.
- R3: When the detector is armed, `vsync_n` falls at the third clock edge after the input rise that ends a broad pulse. The input passes through two synchronizer flops and one output register.
- R4: A rising edge that ends a short low interval never starts a pulse.
- R5: When the input stays low until the low-time count reaches DFLT_TICKS (default 62) and the detector is armed, `vsync_n` falls without any rising edge.
- R6: Every pulse lasts exactly VS_TICKS ticks (default 230), counted after the cycle that started it, whether a broad pulse or the timeout started it.
- R7: Once a pulse has started, further broad-pulse edges and timeouts start no new pulse, so one vertical interval yields exactly one pulse.
- R8: The detector re-arms only when a short pulse ends while `vsync_n` is high. Broad pulses alone, after a pulse, never re-arm it.
- R9: A trigger event or a short-pulse end that falls in the cycle where the pulse expires neither retriggers nor re-arms the detector.
- R10: In cycles with `tick` low, the low-time and width counters hold, so no timeout and no pulse end can occur without ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one cycle wide; all durations count these |
| csync_n | input | 1 | Composite sync, active low, asynchronous |
| vsync_n | output | 1 | Vertical sync pulse, active low |

## Verification
Two events can land in the same clock cycle: the expiry of the output pulse (its last width tick) and the end of a broad low interval, which would otherwise be a trigger. The bench provokes this by starting a pulse through the timeout and holding the input low through the whole pulse. It then releases the input at a sweep of eight cycle offsets around the expected expiry, so the detected rising edge lands before, on and after the final width tick. Each case is judged by a pulse count of one, a width of exactly VS_TICKS, and a cycle-by-cycle match of the output against a bench model built from the requirements.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

   // Per-cycle events derived from the synchronized sync level
   typedef struct packed {
      logic rise;        // synchronized input went high this cycle
      logic long_rise;   // rise ending a broad (serration) low interval
      logic short_rise;  // rise ending a short low interval
      logic timeout;     // low interval has reached the default delay
   } vsd_evt_t;

endpackage

// File: rtl/vsd_sync.sv
module vsd_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   initial begin
      assert (STAGES >= 1) else $error("vsd_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) chain <= RST_VAL;
            else     chain <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) chain <= {STAGES{RST_VAL}};
            else     chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/vsd_lowmeter.sv
module vsd_lowmeter
   import vsd_pkg::*;
#(
   parameter int CNT_W      = 9,
   parameter int SERR_TICKS = 16,
   parameter int DFLT_TICKS = 62
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     tick,
   input  logic     lvl,
   output vsd_evt_t evt
);

   localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] SERR_LIM = CNT_W'(SERR_TICKS);
   localparam logic [CNT_W-1:0] DFLT_LIM = CNT_W'(DFLT_TICKS);

   initial begin
      assert (SERR_TICKS >= 1) else $error("vsd_lowmeter: SERR_TICKS must be positive");
      assert (SERR_TICKS < DFLT_TICKS) else $error("vsd_lowmeter: threshold must be below default delay");
      assert (DFLT_TICKS < (2**CNT_W) - 1) else $error("vsd_lowmeter: CNT_W too narrow");
   end

   logic             prev;
   logic [CNT_W-1:0] lcnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev <= 1'b1;
         lcnt <= '0;
      end else begin
         prev <= lvl;
         if (lvl)
            lcnt <= '0;
         else if (tick && lcnt != CNT_MAX)
            lcnt <= lcnt + 1'b1;
      end
   end

   always_comb begin
      evt.rise       = lvl & ~prev;
      evt.long_rise  = evt.rise & (lcnt >= SERR_LIM);
      evt.short_rise = evt.rise & (lcnt <  SERR_LIM);
      evt.timeout    = ~lvl & (lcnt >= DFLT_LIM);
   end

   // R10: without a tick the low count cannot move while the input is low
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (!tick && !lvl) |=> $stable(lcnt));

   // R2: a count at or above the threshold survives until the input rises
   p_meas_r2: assert property (@(posedge clk) disable iff (rst)
      (!lvl && lcnt >= SERR_LIM) |=> (lcnt >= SERR_LIM || $past(lvl) || rst));

endmodule

// File: rtl/vsd_pulsegen.sv
module vsd_pulsegen
   import vsd_pkg::*;
#(
   parameter int VS_TICKS = 230
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     tick,
   input  vsd_evt_t evt,
   output logic     vsync_n
);

   localparam int              VW      = $clog2(VS_TICKS + 1);
   localparam logic [VW-1:0]   LAST_CT = VW'(VS_TICKS - 1);

   initial begin
      assert (VS_TICKS >= 2) else $error("vsd_pulsegen: VS_TICKS must be at least 2");
   end

   logic          armed;
   logic [VW-1:0] vcnt;
   logic          trig;

   assign trig = armed & (evt.long_rise | evt.timeout);

   always_ff @(posedge clk) begin
      if (rst) begin
         vsync_n <= 1'b1;
         vcnt    <= '0;
         armed   <= 1'b1;
      end else if (trig) begin
         vsync_n <= 1'b0;
         vcnt    <= '0;
         armed   <= 1'b0;
      end else if (!vsync_n) begin
         if (tick) begin
            if (vcnt == LAST_CT) vsync_n <= 1'b1;
            else                 vcnt    <= vcnt + 1'b1;
         end
      end else if (evt.short_rise) begin
         armed <= 1'b1;
      end
   end

   // R7: a pulse can only start from the armed state
   p_fire_armed_r7: assert property (@(posedge clk) disable iff (rst)
      $fell(vsync_n) |-> $past(armed));

   // R7: while disarmed, no new pulse can start
   p_no_retrig_r7: assert property (@(posedge clk) disable iff (rst)
      !armed |=> !$fell(vsync_n));

   // R8: re-arming needs a short pulse end seen while idle
   p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
      $rose(armed) |-> ($past(vsync_n) && $past(evt.short_rise)));

   // R6: width counter stays inside the pulse length
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
      !vsync_n |-> (vcnt <= LAST_CT));

   // R6: pulse ends only on a tick at the final count
   p_end_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(vsync_n) |-> ($past(vcnt) == LAST_CT && $past(tick)));

endmodule

// File: rtl/vsync_detector.sv
module vsync_detector
   import vsd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 9,
   parameter int SERR_TICKS  = 16,
   parameter int DFLT_TICKS  = 62,
   parameter int VS_TICKS    = 230
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic csync_n,
   output logic vsync_n
);

   logic     lvl;
   vsd_evt_t evt;

   vsd_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (csync_n),
      .q   (lvl)
   );

   vsd_lowmeter #(
      .CNT_W      (CNT_W),
      .SERR_TICKS (SERR_TICKS),
      .DFLT_TICKS (DFLT_TICKS)
   ) u_meter (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .lvl  (lvl),
      .evt  (evt)
   );

   vsd_pulsegen #(
      .VS_TICKS (VS_TICKS)
   ) u_pulse (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .evt     (evt),
      .vsync_n (vsync_n)
   );

   // R1: reset leaves the output idle high
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |=> vsync_n);

   // R4: the end of a short low interval never launches a pulse
   p_short_quiet_r4: assert property (@(posedge clk) disable iff (rst)
      evt.short_rise |=> !$fell(vsync_n));

   // R3: a pulse only starts after a broad-pulse end or a timeout
   p_cause_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(vsync_n) |-> ($past(evt.long_rise) || $past(evt.timeout)));

endmodule

// File: tb/tb_vsync_detector.sv
module tb_vsync_detector;

   localparam int SERR = 16;
   localparam int DFLT = 62;
   localparam int VS   = 230;
   localparam int TP   = 4;     // clocks per tick
   localparam int LMAX = 511;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic csync_n = 1'b1;
   logic tick_en = 1'b1;
   logic tick;
   logic vsync_n;
   int   cyc = 0;

   always #10 clk = ~clk;   // 50 MHz

   always @(posedge clk) cyc <= cyc + 1;
   assign tick = tick_en && (cyc % TP == 0);

   vsync_detector dut (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .csync_n (csync_n),
      .vsync_n (vsync_n)
   );

   int total = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   // ---------------- reference model built from the requirements --------
   logic m1 = 1'b1, m2 = 1'b1, m3 = 1'b1, m_vs = 1'b1, m_arm = 1'b1;
   int   m_lc = 0, m_vc = 0;

   always @(posedge clk) begin
      bit rise, trig, shrt;
      if (rst) begin
         m1 = 1'b1; m2 = 1'b1; m3 = 1'b1;
         m_vs = 1'b1; m_arm = 1'b1; m_lc = 0; m_vc = 0;
      end else begin
         rise = m2 && !m3;
         shrt = rise && (m_lc < SERR);
         trig = m_arm && ((rise && m_lc >= SERR) || (!m2 && m_lc >= DFLT));
         if (trig) begin
            m_vs = 1'b0; m_vc = 0; m_arm = 1'b0;
         end else if (!m_vs) begin
            if (tick) begin
               if (m_vc == VS - 1) m_vs = 1'b1;
               else                m_vc++;
            end
         end else if (shrt) begin
            m_arm = 1'b1;
         end
         if (m2)                          m_lc = 0;
         else if (tick && m_lc != LMAX)   m_lc++;
         m3 = m2; m2 = m1; m1 = csync_n;
      end
   end

   // ---------------- output monitor -------------------------------------
   logic prev_vs = 1'b1;
   int   falls = 0, fall_cyc = 0, wticks = 0, last_w = 0, mism = 0;

   always @(negedge clk) begin
      if (!rst) begin
         if (vsync_n !== m_vs) mism++;
         if (prev_vs && !vsync_n) begin
            falls++;
            fall_cyc = cyc;
            wticks = 0;
         end
         if (!prev_vs && vsync_n) last_w = wticks;
         if (!vsync_n && tick) wticks++;
      end
      prev_vs = vsync_n;
   end

   // ---------------- stimulus helpers -----------------------------------
   int drv_cyc = 0;

   task automatic pulse(input int low_clk, input int tot_clk, input bit mark);
      csync_n = 1'b0;
      repeat (low_clk) @(negedge clk);
      csync_n = 1'b1;
      if (mark) drv_cyc = cyc;
      repeat (tot_clk - low_clk) @(negedge clk);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++)
         pulse((4 + $urandom_range(2)) * TP + $urandom_range(3), 64 * TP, 1'b0);
   endtask

   task automatic eqs(input int n);
      for (int i = 0; i < n; i++)
         pulse(2 * TP + $urandom_range(3), 32 * TP, 1'b0);
   endtask

   task automatic serrs(input int n, input int low_clk, input bit mark_first);
      for (int i = 0; i < n; i++)
         pulse(low_clk, 32 * TP, mark_first && (i == 0));
   endtask

   // kinds: 0 standard, 1 timeout, 2 no vertical content
   function automatic int exp_falls(input int kind);
      return (kind == 2) ? 0 : 1;
   endfunction

   task automatic field(input int kind, output int tfall);
      tfall = 0;
      lines(3);
      eqs(6);
      if (kind == 0) begin
         serrs(6, (24 + $urandom_range(4)) * TP + $urandom_range(3), 1'b1);
         eqs(6);
      end else if (kind == 1) begin
         csync_n = 1'b0;
         tfall = cyc;
         repeat ((DFLT + 8 + $urandom_range(10)) * TP) @(negedge clk);
         csync_n = 1'b1;
         repeat (20 * TP) @(negedge clk);
      end else begin
         eqs(8);
      end
      lines(6);
   endtask

   // ---------------- watchdog -------------------------------------------
   initial begin
      repeat (190000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      summary();
      $finish;
   end

   // ---------------- main sequence --------------------------------------
   initial begin
      int f0, m0, tf;
      void'($urandom(32'd1881));
      repeat (5) @(negedge clk);
      chk(vsync_n === 1'b1, "R1", "output during reset", int'(vsync_n), 1);
      rst = 1'b0;
      @(negedge clk);
      chk(vsync_n === 1'b1, "R1", "output after reset", int'(vsync_n), 1);

      // standard field: latency, width, count
      f0 = falls; m0 = mism;
      field(0, tf);
      chk(falls - f0 == 1, "R7", "pulses in standard field", falls - f0, 1);
      chk(fall_cyc - drv_cyc == 3, "R3", "serration rise to fall latency", fall_cyc - drv_cyc, 3);
      chk(last_w == VS, "R6", "normal pulse width in ticks", last_w, VS);
      chk(mism == m0, "R2", "model agreement standard field", mism - m0, 0);

      // timeout field
      f0 = falls; m0 = mism;
      field(1, tf);
      chk(falls - f0 == 1, "R5", "pulses in timeout field", falls - f0, 1);
      chk(fall_cyc - tf >= DFLT * TP && fall_cyc - tf <= DFLT * TP + TP + 4,
          "R5", "low to timeout fall distance", fall_cyc - tf, DFLT * TP);
      chk(last_w == VS, "R6", "default pulse width in ticks", last_w, VS);
      chk(mism == m0, "R5", "model agreement timeout field", mism - m0, 0);

      // only short pulses: nothing
      f0 = falls;
      field(2, tf);
      chk(falls - f0 == 0, "R4", "pulses with short lows only", falls - f0, 0);

      // threshold boundary: SERR-1 ticks is short, SERR ticks is broad
      f0 = falls; m0 = mism;
      lines(3); eqs(6); serrs(6, (SERR - 1) * TP, 1'b0); lines(3);
      chk(falls - f0 == 0, "R2", "lows of threshold minus one", falls - f0, 0);
      f0 = falls;
      lines(2); eqs(6); serrs(6, SERR * TP, 1'b1); lines(6);
      chk(falls - f0 == 1, "R2", "lows exactly at threshold", falls - f0, 1);
      chk(mism == m0, "R2", "model agreement at threshold", mism - m0, 0);

      // re-arm only by a short pulse while idle
      f0 = falls; m0 = mism;
      lines(3); eqs(6); serrs(26, 26 * TP, 1'b0);
      chk(falls - f0 == 1, "R8", "broad pulses alone do not re-arm", falls - f0, 1);
      lines(1); serrs(3, 26 * TP, 1'b0);
      chk(falls - f0 == 2, "R8", "short pulse re-arms", falls - f0, 2);
      lines(6);
      chk(mism == m0, "R8", "model agreement re-arm", mism - m0, 0);

      // no ticks: counters hold, no timeout
      f0 = falls;
      lines(2);
      tick_en = 1'b0;
      csync_n = 1'b0;
      repeat ((DFLT + 40) * TP) @(negedge clk);
      chk(vsync_n === 1'b1, "R10", "no timeout without ticks", int'(vsync_n), 1);
      csync_n = 1'b1;
      repeat (8) @(negedge clk);
      tick_en = 1'b1;
      lines(3);
      chk(falls - f0 == 0, "R10", "pulses with ticks stopped", falls - f0, 0);

      // coincidence: input rise detected around the final width tick
      for (int k = 0; k < 8; k++) begin
         int t0, guard;
         f0 = falls; m0 = mism;
         lines(2);
         csync_n = 1'b0;
         guard = 0;
         while (vsync_n === 1'b1 && guard < 2000) begin
            @(negedge clk);
            guard++;
         end
         t0 = cyc;
         while (cyc < t0 + VS * TP - 4 + k) @(negedge clk);
         csync_n = 1'b1;
         repeat (40 * TP) @(negedge clk);
         lines(3);
         chk(falls - f0 == 1, "R9", "single pulse at expiry overlap", falls - f0, 1);
         chk(last_w == VS, "R9", "width at expiry overlap", last_w, VS);
         chk(mism == m0, "R9", "model agreement at expiry overlap", mism - m0, 0);
      end

      // constrained random fields
      for (int i = 0; i < 6; i++) begin
         int kind;
         kind = $urandom_range(2);
         f0 = falls; m0 = mism;
         field(kind, tf);
         chk(falls - f0 == exp_falls(kind), "R7", "pulses in random field", falls - f0, exp_falls(kind));
         chk(mism == m0, "R2", "model agreement random field", mism - m0, 0);
      end

      summary();
      $finish;
   end

endmodule